// File: doc/BRIEF.md
# Physical Register Rename Stage

This block renames a group of decoded instructions per clock for a machine that keeps committed and speculative values in one physical register file. A speculative map translates each architectural register to a physical tag. Source operands are looked up through that map and no register values are read. An instruction that writes a register takes a fresh tag from a free pool, and the map is pointed at that tag. The tag that the destination held before is returned to the caller, which keeps it with the instruction and releases it when the instruction commits.

A commit port updates a committed copy of the map and returns the released tag to the pool. Commit moves no data. A branch port works with a small set of map snapshots. Each predicted branch in a rename group claims a slot that holds the map as it stands just after the branch. A misprediction rolls the map back to that copy and reclaims every tag handed out after the branch. A correct prediction only releases the slot. An exception input rolls the map back to the committed copy and rebuilds the pool, so that it holds every tag the committed map does not use.

Top module: `phys_rename`

## Requirements
- R1: After reset, architectural register a maps to tag a, tags NUM_ARCH to NUM_PHYS-1 are free, no snapshot slot is in use and the stage is ready.
- R2: Each source tag output equals the current map entry of the named register, unless an earlier lane of the same group writes that register.
- R3: Lanes that write a register take free tags in lane order, each taking the lowest-numbered free tag that remains. The map then returns that tag for the register.
- R4: The prior-tag output of a writing lane is the mapping its destination had just before that lane, including the effect of earlier lanes in the same group.
- R5: A source or destination that names the destination of an earlier lane in the same group sees that lane's new tag.
- R6: A commit sets the committed mapping of its register to the given new tag. It returns the given prior tag to the free pool, where it can be allocated from the next cycle.
- R7: The stage is not ready while fewer than RN_WIDTH tags are free. It is also not ready when a lane carries a branch and all NUM_SNAP slots are in use. A group offered while the stage is not ready changes no state.
- R8: A branch lane claims the lowest-numbered idle snapshot slot and reports it on the snapshot id output. A misprediction on that slot restores the map to its state just after the branch lane. It frees every tag allocated after the branch and drops the slot together with every slot claimed after it.
- R9: A correct resolution releases its slot and leaves the map and the free pool unchanged.
- R10: An exception restores the map to the committed map and frees exactly the tags the committed map does not use. It also clears all snapshot slots.
- R11: The stage is not ready in a cycle that carries an exception or a misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | RN_WIDTH | Lane holds an instruction |
| ren_dst_en_i | input | RN_WIDTH | Lane writes a register |
| ren_dst_i | input | RN_WIDTH x AW | Destination architectural register per lane |
| ren_src1_i | input | RN_WIDTH x AW | First source architectural register per lane |
| ren_src2_i | input | RN_WIDTH x AW | Second source architectural register per lane |
| ren_branch_i | input | RN_WIDTH | Lane is a predicted branch (at most one per group) |
| ren_ready_o | output | 1 | Group is renamed this cycle |
| ren_src1_tag_o | output | RN_WIDTH x PW | Physical tag of first source |
| ren_src2_tag_o | output | RN_WIDTH x PW | Physical tag of second source |
| ren_new_tag_o | output | RN_WIDTH x PW | Newly allocated destination tag |
| ren_old_tag_o | output | RN_WIDTH x PW | Prior tag of the destination |
| ren_snap_id_o | output | SW | Snapshot slot claimed by the branch lane |
| cmt_valid_i | input | 1 | Commit of one writing instruction |
| cmt_arch_i | input | AW | Committed architectural register |
| cmt_new_tag_i | input | PW | Tag that becomes the committed mapping |
| cmt_old_tag_i | input | PW | Prior tag released to the pool |
| br_valid_i | input | 1 | Branch resolution |
| br_snap_i | input | SW | Slot of the resolving branch |
| br_mispredict_i | input | 1 | Resolution is a misprediction |
| exc_i | input | 1 | Exception recovery |

## Verification
The bench builds the block with 8 architectural registers, 16 physical tags, two lanes and four snapshot slots. That leaves only eight tags in flight, so the pool runs dry within a few groups and the stall on an empty pool occurs often. Four slots fill often enough to reach the stall on busy snapshots. With only eight register names, same-group collisions between sources and destinations are common, and so are mispredictions that land on nested branches whose younger slots must be dropped. Exceptions arrive while several branches and many tags are outstanding, so the pool rebuild is exercised with real content.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    FLUSH_NONE,
    FLUSH_BRANCH,
    FLUSH_EXC
  } flush_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NP = 16,
  parameter int NA = 8,
  parameter int RW = 2,
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RW-1:0]          need_i,
  output logic [RW-1:0][PW-1:0]  tag_o,
  output logic [NP-1:0]          alloc_vec_o,
  output logic                   enough_o,
  input  logic                   ret_en_i,
  input  logic [PW-1:0]          ret_tag_i,
  input  logic [NP-1:0]          reclaim_i,
  input  logic                   rebuild_en_i,
  input  logic [NP-1:0]          rebuild_i
);
  localparam logic [NP-1:0] RESET_FREE = {NP{1'b1}} << NA;

  logic [NP-1:0] free_q, free_d, avail, ret_vec;
  logic          hit;

  // lanes pick in order, each the lowest remaining free tag
  always_comb begin
    avail       = free_q;
    alloc_vec_o = '0;
    tag_o       = '0;
    hit         = 1'b0;
    for (int i = 0; i < RW; i++) begin
      hit = 1'b0;
      for (int t = 0; t < NP; t++) begin
        if (!hit && avail[t]) begin
          tag_o[i] = PW'(t);
          hit      = 1'b1;
        end
      end
      if (need_i[i]) begin
        avail[tag_o[i]]       = 1'b0;
        alloc_vec_o[tag_o[i]] = 1'b1;
      end
    end
  end

  assign enough_o = $countones(free_q) >= RW;
  assign ret_vec  = ret_en_i ? (NP'(1) << ret_tag_i) : '0;

  always_comb begin
    if (rebuild_en_i) free_d = rebuild_i;
    else              free_d = (free_q & ~alloc_vec_o) | ret_vec | reclaim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= RESET_FREE;
    else         free_q <= free_d;
  end

  // a released tag must be in use
  p_ret_in_use_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_en_i |-> !free_q[ret_tag_i]);

  // rebuilt pool holds exactly the tags outside the committed map
  p_rebuild_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rebuild_en_i |=> $countones(free_q) == NP - NA);
endmodule

// File: rtl/rn_map.sv
module rn_map #(
  parameter int NA = 8,
  parameter int NP = 16,
  parameter int RW = 2,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RW-1:0]          go_i,
  input  logic [RW-1:0]          dst_en_i,
  input  logic [RW-1:0][AW-1:0]  dst_i,
  input  logic [RW-1:0][AW-1:0]  src1_i,
  input  logic [RW-1:0][AW-1:0]  src2_i,
  input  logic [RW-1:0][PW-1:0]  new_tag_i,
  input  logic [RW-1:0]          snap_lane_i,
  output logic [RW-1:0][PW-1:0]  src1_tag_o,
  output logic [RW-1:0][PW-1:0]  src2_tag_o,
  output logic [RW-1:0][PW-1:0]  old_tag_o,
  output logic [NA-1:0][PW-1:0]  snap_map_o,
  input  logic                   restore_en_i,
  input  logic [NA-1:0][PW-1:0]  restore_map_i,
  input  logic                   cmt_en_i,
  input  logic [AW-1:0]          cmt_arch_i,
  input  logic [PW-1:0]          cmt_tag_i,
  input  logic                   exc_i,
  output logic [NP-1:0]          cmt_free_o
);
  logic [NA-1:0][PW-1:0] map_q, map_d, work, cmap_q, cmap_d;

  // lane-by-lane walk gives same-group bypass for sources and prior tags
  always_comb begin
    work       = map_q;
    snap_map_o = map_q;
    src1_tag_o = '0;
    src2_tag_o = '0;
    old_tag_o  = '0;
    for (int i = 0; i < RW; i++) begin
      src1_tag_o[i] = work[src1_i[i]];
      src2_tag_o[i] = work[src2_i[i]];
      old_tag_o[i]  = work[dst_i[i]];
      if (go_i[i] && dst_en_i[i]) work[dst_i[i]] = new_tag_i[i];
      if (snap_lane_i[i]) snap_map_o = work;
    end
  end

  always_comb begin
    cmap_d = cmap_q;
    if (cmt_en_i) cmap_d[cmt_arch_i] = cmt_tag_i;
    cmt_free_o = '1;
    for (int a = 0; a < NA; a++) cmt_free_o[cmap_d[a]] = 1'b0;
  end

  always_comb begin
    if (exc_i)             map_d = cmap_d;
    else if (restore_en_i) map_d = restore_map_i;
    else                   map_d = work;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NA; a++) begin
        map_q[a]  <= PW'(a);
        cmap_q[a] <= PW'(a);
      end
    end else begin
      map_q  <= map_d;
      cmap_q <= cmap_d;
    end
  end

  for (genvar g = 0; g < RW; g++) begin : g_lane_chk
    // fresh tag never equals the mapping it replaces
    p_new_ne_old_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_i[g] && dst_en_i[g]) |-> new_tag_i[g] != old_tag_o[g]);
  end
endmodule

// File: rtl/rn_snap.sv
module rn_snap #(
  parameter int NS = 4,
  parameter int NA = 8,
  parameter int NP = 16,
  parameter int RW = 2,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   take_i,
  input  logic [NA-1:0][PW-1:0]  take_map_i,
  input  logic [RW-1:0]          alloc_i,
  input  logic [RW-1:0][PW-1:0]  tag_i,
  input  logic [RW-1:0]          br_lane_i,
  input  logic                   res_en_i,
  input  logic [SW-1:0]          res_id_i,
  input  logic                   res_bad_i,
  input  logic                   flush_i,
  output logic [SW-1:0]          slot_o,
  output logic                   slot_ok_o,
  output logic [NA-1:0][PW-1:0]  rb_map_o,
  output logic [NP-1:0]          rb_mask_o
);
  logic [NS-1:0]                 active_q;
  logic [NS-1:0][NS-1:0]         older_q;
  logic [NS-1:0][NA-1:0][PW-1:0] map_q;
  logic [NS-1:0][NP-1:0]         mask_q;
  logic [NS-1:0]                 drop;
  logic [NP-1:0]                 cyc_alloc, new_mask, clr_mask;
  logic                          hit, after;

  always_comb begin
    slot_o = '0;
    hit    = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (!hit && !active_q[s]) begin
        slot_o = SW'(s);
        hit    = 1'b1;
      end
    end
  end
  assign slot_ok_o = ~&active_q;

  // tags handed out this cycle, and those after the branch lane
  always_comb begin
    cyc_alloc = '0;
    new_mask  = '0;
    after     = 1'b0;
    for (int i = 0; i < RW; i++) begin
      if (alloc_i[i]) begin
        cyc_alloc[tag_i[i]] = 1'b1;
        if (after) new_mask[tag_i[i]] = 1'b1;
      end
      if (br_lane_i[i]) after = 1'b1;
    end
  end

  assign rb_map_o  = map_q[res_id_i];
  assign rb_mask_o = mask_q[res_id_i];
  assign clr_mask  = (res_en_i && res_bad_i) ? mask_q[res_id_i] : '0;

  // a misprediction also drops every slot claimed after it
  always_comb begin
    drop = '0;
    if (res_en_i) begin
      drop[res_id_i] = 1'b1;
      if (res_bad_i)
        for (int j = 0; j < NS; j++)
          if (active_q[j] && older_q[j][res_id_i]) drop[j] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      older_q  <= '0;
      map_q    <= '0;
      mask_q   <= '0;
    end else if (flush_i) begin
      active_q <= '0;
      older_q  <= '0;
      mask_q   <= '0;
    end else begin
      active_q <= (active_q & ~drop) | (take_i ? (NS'(1) << slot_o) : '0);
      for (int j = 0; j < NS; j++) begin
        older_q[j] <= older_q[j] & ~drop;
        mask_q[j]  <= (mask_q[j] | cyc_alloc) & ~clr_mask;
      end
      if (take_i) begin
        older_q[slot_o] <= active_q & ~drop;
        mask_q[slot_o]  <= new_mask;
        map_q[slot_o]   <= take_map_i;
      end
    end
  end

  p_res_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_en_i |-> active_q[res_id_i]);

  p_take_has_slot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> slot_ok_o);

  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> active_q == '0);
endmodule

// File: rtl/phys_rename.sv
module phys_rename
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int RN_WIDTH = 2,
  parameter int NUM_SNAP = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int SW = (NUM_SNAP > 1) ? $clog2(NUM_SNAP) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [RN_WIDTH-1:0]          ren_valid_i,
  input  logic [RN_WIDTH-1:0]          ren_dst_en_i,
  input  logic [RN_WIDTH-1:0][AW-1:0]  ren_dst_i,
  input  logic [RN_WIDTH-1:0][AW-1:0]  ren_src1_i,
  input  logic [RN_WIDTH-1:0][AW-1:0]  ren_src2_i,
  input  logic [RN_WIDTH-1:0]          ren_branch_i,
  output logic                         ren_ready_o,
  output logic [RN_WIDTH-1:0][PW-1:0]  ren_src1_tag_o,
  output logic [RN_WIDTH-1:0][PW-1:0]  ren_src2_tag_o,
  output logic [RN_WIDTH-1:0][PW-1:0]  ren_new_tag_o,
  output logic [RN_WIDTH-1:0][PW-1:0]  ren_old_tag_o,
  output logic [SW-1:0]                ren_snap_id_o,
  input  logic                         cmt_valid_i,
  input  logic [AW-1:0]                cmt_arch_i,
  input  logic [PW-1:0]                cmt_new_tag_i,
  input  logic [PW-1:0]                cmt_old_tag_i,
  input  logic                         br_valid_i,
  input  logic [SW-1:0]                br_snap_i,
  input  logic                         br_mispredict_i,
  input  logic                         exc_i
);
  flush_e                        flush;
  logic                          enough, slot_ok, br_req, take;
  logic [RN_WIDTH-1:0]           go, need, br_lane;
  logic [NUM_PHYS-1:0]           alloc_vec, rb_mask, cmt_free;
  logic [NUM_ARCH-1:0][PW-1:0]   snap_map, rb_map;

  always_comb begin
    if (exc_i)                              flush = FLUSH_EXC;
    else if (br_valid_i && br_mispredict_i) flush = FLUSH_BRANCH;
    else                                    flush = FLUSH_NONE;
  end

  assign br_req      = |(ren_valid_i & ren_branch_i);
  assign ren_ready_o = (flush == FLUSH_NONE) && enough && (slot_ok || !br_req);
  assign go          = ren_valid_i & {RN_WIDTH{ren_ready_o}};
  assign need        = go & ren_dst_en_i;
  assign br_lane     = go & ren_branch_i;
  assign take        = |br_lane;

  rn_free_list #(.NP(NUM_PHYS), .NA(NUM_ARCH), .RW(RN_WIDTH)) u_free (
    .clk_i,
    .rst_ni,
    .need_i       (need),
    .tag_o        (ren_new_tag_o),
    .alloc_vec_o  (alloc_vec),
    .enough_o     (enough),
    .ret_en_i     (cmt_valid_i),
    .ret_tag_i    (cmt_old_tag_i),
    .reclaim_i    ((flush == FLUSH_BRANCH) ? rb_mask : '0),
    .rebuild_en_i (flush == FLUSH_EXC),
    .rebuild_i    (cmt_free)
  );

  rn_map #(.NA(NUM_ARCH), .NP(NUM_PHYS), .RW(RN_WIDTH)) u_map (
    .clk_i,
    .rst_ni,
    .go_i          (go),
    .dst_en_i      (ren_dst_en_i),
    .dst_i         (ren_dst_i),
    .src1_i        (ren_src1_i),
    .src2_i        (ren_src2_i),
    .new_tag_i     (ren_new_tag_o),
    .snap_lane_i   (br_lane),
    .src1_tag_o    (ren_src1_tag_o),
    .src2_tag_o    (ren_src2_tag_o),
    .old_tag_o     (ren_old_tag_o),
    .snap_map_o    (snap_map),
    .restore_en_i  (flush == FLUSH_BRANCH),
    .restore_map_i (rb_map),
    .cmt_en_i      (cmt_valid_i),
    .cmt_arch_i    (cmt_arch_i),
    .cmt_tag_i     (cmt_new_tag_i),
    .exc_i         (flush == FLUSH_EXC),
    .cmt_free_o    (cmt_free)
  );

  rn_snap #(.NS(NUM_SNAP), .NA(NUM_ARCH), .NP(NUM_PHYS), .RW(RN_WIDTH)) u_snap (
    .clk_i,
    .rst_ni,
    .take_i     (take),
    .take_map_i (snap_map),
    .alloc_i    (need),
    .tag_i      (ren_new_tag_o),
    .br_lane_i  (br_lane),
    .res_en_i   (br_valid_i),
    .res_id_i   (br_snap_i),
    .res_bad_i  (br_mispredict_i),
    .flush_i    (flush == FLUSH_EXC),
    .slot_o     (ren_snap_id_o),
    .slot_ok_o  (slot_ok),
    .rb_map_o   (rb_map),
    .rb_mask_o  (rb_mask)
  );

  p_one_branch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ren_valid_i & ren_branch_i) <= 1);

  p_flush_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i || (br_valid_i && br_mispredict_i)) |-> go == '0);

  if (RN_WIDTH > 1) begin : g_byp_chk
    p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go[0] && go[1] && ren_dst_en_i[0] && ren_src1_i[1] == ren_dst_i[0])
        |-> ren_src1_tag_o[1] == ren_new_tag_o[0]);
  end
endmodule

// File: tb/phys_rename_bench.sv
module phys_rename_bench;
  localparam int NA = 8, NP = 16, RW = 2, NS = 4;
  localparam int AW = 3, PW = 4, SW = 2;
  localparam int CYCLES = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0]          valid, dst_en, branch;
  logic [RW-1:0][AW-1:0]  dst, src1, src2;
  logic                   ready;
  logic [RW-1:0][PW-1:0]  s1_tag, s2_tag, n_tag, o_tag;
  logic [SW-1:0]          snap_id;
  logic                   cmt_v, br_v, br_bad, exc;
  logic [AW-1:0]          cmt_arch;
  logic [PW-1:0]          cmt_new, cmt_old;
  logic [SW-1:0]          br_id;

  phys_rename u_phys_rename (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(valid), .ren_dst_en_i(dst_en), .ren_dst_i(dst),
    .ren_src1_i(src1), .ren_src2_i(src2), .ren_branch_i(branch),
    .ren_ready_o(ready), .ren_src1_tag_o(s1_tag), .ren_src2_tag_o(s2_tag),
    .ren_new_tag_o(n_tag), .ren_old_tag_o(o_tag), .ren_snap_id_o(snap_id),
    .cmt_valid_i(cmt_v), .cmt_arch_i(cmt_arch), .cmt_new_tag_i(cmt_new),
    .cmt_old_tag_i(cmt_old), .br_valid_i(br_v), .br_snap_i(br_id),
    .br_mispredict_i(br_bad), .exc_i(exc)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference
  int m_map[NA], m_cmap[NA];
  bit m_free[NP];
  bit s_act[NS];
  int s_map[NS][NA];
  int s_seq[NS];
  int s_order[$];
  int r_arch[$], r_new[$], r_old[$], r_seq[$];
  int seq = 0;
  string ctx = "R1";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int free_cnt();
    int c = 0;
    for (int t = 0; t < NP; t++) c += m_free[t];
    return c;
  endfunction

  function automatic int snap_cnt();
    int c = 0;
    for (int s = 0; s < NS; s++) c += s_act[s];
    return c;
  endfunction

  task automatic step();
    int w[NA];
    bit wf[NP];
    bit exp_ready, brreq, written[NA];
    int e, k, pos, bs;
    string tg;
    #1;
    brreq = |(valid & branch);
    exp_ready = !exc && !(br_v && br_bad) && free_cnt() >= RW &&
                (!brreq || snap_cnt() < NS);
    if (exc || (br_v && br_bad)) tg = "R11";
    else if (ctx == "R1") tg = "R1";
    else tg = "R7";
    chk(tg, "ready", int'(ready), int'(exp_ready));
    if (exp_ready) begin
      w = m_map;
      wf = m_free;
      for (int a = 0; a < NA; a++) written[a] = 0;
      for (int i = 0; i < RW; i++) begin
        if (!valid[i]) continue;
        tg = written[src1[i]] ? "R5" : (ctx != "" ? ctx : "R2");
        chk(tg, "src1", int'(s1_tag[i]), w[src1[i]]);
        tg = written[src2[i]] ? "R5" : (ctx != "" ? ctx : "R2");
        chk(tg, "src2", int'(s2_tag[i]), w[src2[i]]);
        if (dst_en[i]) begin
          tg = written[dst[i]] ? "R5" : (ctx != "" ? ctx : "R4");
          chk(tg, "old", int'(o_tag[i]), w[dst[i]]);
          e = -1;
          for (int t = NP - 1; t >= 0; t--) if (wf[t]) e = t;
          chk(ctx != "" ? ctx : "R3", "new", int'(n_tag[i]), e);
          wf[e] = 0;
          r_arch.push_back(int'(dst[i]));
          r_new.push_back(e);
          r_old.push_back(w[dst[i]]);
          r_seq.push_back(seq);
          w[dst[i]] = e;
          written[dst[i]] = 1;
        end
        if (branch[i]) begin
          e = -1;
          for (int s = NS - 1; s >= 0; s--) if (!s_act[s]) e = s;
          chk("R8", "snap_id", int'(snap_id), e);
          s_act[e] = 1;
          s_map[e] = w;
          s_seq[e] = seq;
          s_order.push_back(e);
        end
        seq++;
      end
      m_map = w;
      m_free = wf;
    end
    ctx = "";
    if (exc) begin
      m_map = m_cmap;
      foreach (r_new[q]) m_free[r_new[q]] = 1;
      r_arch.delete(); r_new.delete(); r_old.delete(); r_seq.delete();
      for (int s = 0; s < NS; s++) s_act[s] = 0;
      s_order.delete();
      ctx = "R10";
    end else begin
      if (cmt_v) begin
        m_cmap[r_arch[0]] = r_new[0];
        m_free[r_old[0]] = 1;
        void'(r_arch.pop_front()); void'(r_new.pop_front());
        void'(r_old.pop_front()); void'(r_seq.pop_front());
        ctx = "R6";
      end
      if (br_v) begin
        k = int'(br_id);
        pos = 0;
        foreach (s_order[q]) if (s_order[q] == k) pos = q;
        if (br_bad) begin
          m_map = s_map[k];
          bs = s_seq[k];
          while (r_seq.size() > 0 && r_seq[r_seq.size()-1] > bs) begin
            m_free[r_new[r_new.size()-1]] = 1;
            void'(r_arch.pop_back()); void'(r_new.pop_back());
            void'(r_old.pop_back()); void'(r_seq.pop_back());
          end
          while (s_order.size() > pos) begin
            s_act[s_order[s_order.size()-1]] = 0;
            void'(s_order.pop_back());
          end
          ctx = "R8";
        end else begin
          s_act[k] = 0;
          s_order.delete(pos);
          ctx = "R9";
        end
      end
    end
  endtask

  task automatic idle_inputs();
    valid = '0; dst_en = '0; branch = '0; dst = '0; src1 = '0; src2 = '0;
    cmt_v = 0; cmt_arch = '0; cmt_new = '0; cmt_old = '0;
    br_v = 0; br_id = '0; br_bad = 0; exc = 0;
  endtask

  task automatic gen();
    int min_seq, l;
    bit ok;
    idle_inputs();
    for (int i = 0; i < RW; i++) begin
      valid[i]  = ($urandom % 10) < 8;
      dst_en[i] = ($urandom % 100) < 85;
      dst[i]    = AW'($urandom % NA);
      src1[i]   = AW'($urandom % NA);
      src2[i]   = AW'($urandom % NA);
    end
    if (($urandom % 100) < 15) begin
      l = $urandom % RW;
      branch[l] = valid[l];
    end
    min_seq = 32'h7fffffff;
    for (int s = 0; s < NS; s++) if (s_act[s] && s_seq[s] < min_seq) min_seq = s_seq[s];
    ok = r_seq.size() > 0 && r_seq[0] < min_seq;
    if (ok && ($urandom % 2)) begin
      cmt_v = 1; cmt_arch = AW'(r_arch[0]);
      cmt_new = PW'(r_new[0]); cmt_old = PW'(r_old[0]);
    end
    if (s_order.size() > 0 && ($urandom % 100) < 20) begin
      br_v = 1;
      br_id = SW'(s_order[$urandom % s_order.size()]);
      br_bad = ($urandom % 100) < 35;
    end
    if (($urandom % 150) == 0) begin
      exc = 1; cmt_v = 0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin m_map[a] = a; m_cmap[a] = a; end
    for (int t = 0; t < NP; t++) m_free[t] = t >= NA;
    for (int s = 0; s < NS; s++) s_act[s] = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: identity lookups, no writes
    valid = '1;
    for (int i = 0; i < RW; i++) begin
      src1[i] = AW'(2 * i + 1);
      src2[i] = AW'(NA - 1 - i);
    end
    step();
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      gen();
      step();
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule